// File: doc/BRIEF.md
# Speed Sensor Offset Calibration and Zero-Crossing Controller

This block is the digital core of a differential magnetic wheel-speed sensor. It receives signed samples of the differential field from a tracking converter, follows the signal's alternating peaks and valleys, and drives a signed code for the offset-cancellation converter. The speed bit it produces follows the sign of the offset-corrected signal, so it switches at the midpoint between the most recent peak and valley.

After reset, and again whenever the input has stopped, the block starts in a blind window in which samples are ignored. It then collects a set number of qualified reversals with the speed bit held low. On the last of these it loads the mean of the latest peak and valley into the offset code and begins switching. While running, the offset code moves by at most one step at a time. A step is taken only when the midpoint error stays outside a dead band on two half periods in a row, so the code does not dither. Swings too small to pass the arming limit never move the speed bit. A lack of qualified reversals for a full standstill interval restarts the whole sequence.

Top module: `speed_offset_tracker`

## Requirements
- R1: While rst_ni is low and right after it is released, speed_o is 0 and dac_code_o is 0.
- R2: From reset or a standstill restart until the CAL_EDGES-th qualified reversal, speed_o stays 0.
- R3: On the CAL_EDGES-th qualified reversal, dac_code_o takes floor((peak + valley) / 2) of the most recent peak and valley, saturated to the signed DAC_W range.
- R4: A reversal counts as qualified only when the input has moved back from its running extreme by strictly more than EDGE_THR codes. A move back of exactly EDGE_THR codes is not counted.
- R5: Once calibrated, speed_o goes to 1 when sample_i - dac_code_o rises above +HYST, provided it has been at or below -LIMIT_THR since the last switch. It goes to 0 under the mirror condition. This gives one rising edge per signal period, and speed_o is 0 at a valley.
- R6: A signal whose offset-corrected value stays strictly inside ±LIMIT_THR never toggles speed_o.
- R7: Once calibrated, dac_code_o changes by one LSB only when the midpoint error exceeds DEAD_BAND with the same sign on two consecutive qualified reversals. An offset drift of DEAD_BAND or less leaves the code unchanged. A larger drift d settles at the old code plus d - DEAD_BAND.
- R8: After STANDSTILL_CYC cycles without a qualified reversal, the block returns to uncalibrated mode. speed_o is forced to 0 and dac_code_o keeps its value.
- R9: For BLIND_CYC cycles after reset or a standstill restart, samples are ignored. Neither the extremes nor the offset code they would produce appear at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Marks a new converter sample |
| sample_i | input | SAMPLE_W | Signed differential field sample |
| dac_code_o | output | DAC_W | Signed offset-cancellation code |
| speed_o | output | 1 | Speed bit, 0 while uncalibrated |

## Verification
Triangle waves at several offsets, including negative, zero and positive values, show whether the loaded code equals the arithmetic midpoint, whether the output stays low until the third reversal, and whether it then gives exactly one pulse per period. Wiggles of exactly the edge threshold placed before real swings tell a strict threshold apart from an inclusive one. Sub-limit oscillation separates the arming limit from the plain hysteresis. Offset drifts of two and seven codes separate the dead band from a plain tracking loop. A long hold followed by a single spike inside the blind window shows that standstill restarts calibration, keeps the code, and ignores samples taken during the blind window.

// File: rtl/spd_cal_pkg.sv
package spd_cal_pkg;
  typedef enum logic [1:0] {
    PH_BLIND = 2'd0,
    PH_ACQ   = 2'd1,
    PH_RUN   = 2'd2
  } cal_phase_e;
endpackage

// File: rtl/spd_edge_qual.sv
module spd_edge_qual #(
  parameter int SW       = 10,
  parameter int EDGE_THR = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 clr_i,
  input  logic signed [SW-1:0] x_i,
  output logic                 edge_o,
  output logic                 is_peak_o,
  output logic signed [SW-1:0] extreme_o
);
  localparam int DW = SW + 1;
  localparam logic signed [DW-1:0] THR_S = DW'(EDGE_THR);

  logic                 seeded_q, dir_up_q;
  logic signed [SW-1:0] ext_q;
  logic signed [DW-1:0] x_w, ext_w, back_w;

  assign x_w    = {x_i[SW-1], x_i};
  assign ext_w  = {ext_q[SW-1], ext_q};
  assign back_w = dir_up_q ? (ext_w - x_w) : (x_w - ext_w);

  assign edge_o    = en_i && seeded_q && (back_w > THR_S);
  assign is_peak_o = dir_up_q;
  assign extreme_o = ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      dir_up_q <= 1'b1;
      ext_q    <= '0;
    end else if (clr_i) begin
      seeded_q <= 1'b0;
    end else if (en_i) begin
      if (!seeded_q) begin
        seeded_q <= 1'b1;
        dir_up_q <= 1'b1;
        ext_q    <= x_i;
      end else if (edge_o) begin
        dir_up_q <= ~dir_up_q;
        ext_q    <= x_i;
      end else if (dir_up_q ? (x_i > ext_q) : (x_i < ext_q)) begin
        ext_q <= x_i;
      end
    end
  end
endmodule

// File: rtl/spd_offset_loop.sv
module spd_offset_loop #(
  parameter int SW        = 10,
  parameter int DAC_W     = 8,
  parameter int DEAD_BAND = 2,
  parameter int CAL_EDGES = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    edge_i,
  input  logic                    is_peak_i,
  input  logic signed [SW-1:0]    extreme_i,
  input  logic                    clr_i,
  input  logic                    acq_i,
  input  logic                    run_i,
  output logic                    cal_load_o,
  output logic signed [DAC_W-1:0] dac_o
);
  localparam int MW    = SW + 2;
  localparam int CNT_W = $clog2(CAL_EDGES + 1);
  localparam logic signed [MW-1:0] DMAX = MW'(2 ** (DAC_W - 1) - 1);
  localparam logic signed [MW-1:0] DMIN = MW'(-(2 ** (DAC_W - 1)));
  localparam logic signed [MW-1:0] DB_P = MW'(DEAD_BAND);
  localparam logic signed [MW-1:0] DB_N = MW'(-DEAD_BAND);

  logic signed [SW-1:0]    peak_q, valley_q, pk_n, vl_n;
  logic signed [MW-1:0]    sum_w, mean_w, dac_w, err_w;
  logic signed [DAC_W-1:0] mean_sat;
  logic [CNT_W-1:0]        cnt_q;
  logic                    up_q, dn_q;

  assign pk_n   = is_peak_i ? extreme_i : peak_q;
  assign vl_n   = is_peak_i ? valley_q : extreme_i;
  assign sum_w  = {{2{pk_n[SW-1]}}, pk_n} + {{2{vl_n[SW-1]}}, vl_n};
  assign mean_w = sum_w >>> 1;
  assign dac_w  = {{(MW-DAC_W){dac_o[DAC_W-1]}}, dac_o};
  assign err_w  = mean_w - dac_w;

  always_comb begin
    if (mean_w > DMAX)      mean_sat = DMAX[DAC_W-1:0];
    else if (mean_w < DMIN) mean_sat = DMIN[DAC_W-1:0];
    else                    mean_sat = mean_w[DAC_W-1:0];
  end

  assign cal_load_o = edge_i && acq_i && (cnt_q == CNT_W'(CAL_EDGES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q   <= '0;
      valley_q <= '0;
      cnt_q    <= '0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      dac_o    <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else if (edge_i) begin
      peak_q   <= pk_n;
      valley_q <= vl_n;
      if (cal_load_o) begin
        dac_o <= mean_sat;
        up_q  <= 1'b0;
        dn_q  <= 1'b0;
      end else if (acq_i) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (run_i) begin
        // step only on a second consecutive same-sign excursion
        if (err_w > DB_P) begin
          dn_q <= 1'b0;
          up_q <= ~up_q;
          if (up_q && dac_w != DMAX) dac_o <= dac_o + 1'b1;
        end else if (err_w < DB_N) begin
          up_q <= 1'b0;
          dn_q <= ~dn_q;
          if (dn_q && dac_w != DMIN) dac_o <= dac_o - 1'b1;
        end else begin
          up_q <= 1'b0;
          dn_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spd_zero_cross.sv
module spd_zero_cross #(
  parameter int SW        = 10,
  parameter int DAC_W     = 8,
  parameter int HYST      = 1,
  parameter int LIMIT_THR = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    run_i,
  input  logic signed [SW-1:0]    x_i,
  input  logic signed [DAC_W-1:0] dac_i,
  output logic                    speed_o
);
  localparam int CW = SW + 1;
  localparam logic signed [CW-1:0] HYS_P = CW'(HYST);
  localparam logic signed [CW-1:0] HYS_N = CW'(-HYST);
  localparam logic signed [CW-1:0] LIM_P = CW'(LIMIT_THR);
  localparam logic signed [CW-1:0] LIM_N = CW'(-LIMIT_THR);

  logic signed [CW-1:0] corr_w;
  logic                 armed_q;

  assign corr_w = {x_i[SW-1], x_i} - {{(CW-DAC_W){dac_i[DAC_W-1]}}, dac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_o <= 1'b0;
      armed_q <= 1'b0;
    end else if (!run_i) begin
      speed_o <= 1'b0;
      armed_q <= 1'b0;
    end else if (valid_i) begin
      if (!speed_o) begin
        if (armed_q && corr_w > HYS_P) begin
          speed_o <= 1'b1;
          armed_q <= 1'b0;
        end else if (corr_w <= LIM_N) begin
          armed_q <= 1'b1;
        end
      end else begin
        if (armed_q && corr_w < HYS_N) begin
          speed_o <= 1'b0;
          armed_q <= 1'b0;
        end else if (corr_w >= LIM_P) begin
          armed_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/speed_offset_tracker.sv
module speed_offset_tracker
  import spd_cal_pkg::*;
#(
  parameter int SAMPLE_W      = 10,
  parameter int DAC_W         = 8,
  parameter int EDGE_THR      = 8,
  parameter int LIMIT_THR     = 6,
  parameter int HYST          = 1,
  parameter int DEAD_BAND     = 2,
  parameter int CAL_EDGES     = 3,
  parameter int STANDSTILL_CYC = 70_000_000,
  parameter int BLIND_CYC     = 30_000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [DAC_W-1:0]    dac_code_o,
  output logic                       speed_o
);
  localparam int ST_W = $clog2(STANDSTILL_CYC + 1);
  localparam int BL_W = $clog2(BLIND_CYC + 1);

  cal_phase_e              phase_q;
  logic [ST_W-1:0]         stand_cnt_q;
  logic [BL_W-1:0]         blind_cnt_q;
  logic                    stand_hit, blind_done, qual_en;
  logic                    edge_w, is_peak_w, cal_load_w;
  logic signed [SAMPLE_W-1:0] extreme_w;

  assign stand_hit  = (stand_cnt_q == ST_W'(STANDSTILL_CYC - 1));
  assign blind_done = (blind_cnt_q == BL_W'(BLIND_CYC - 1));
  assign qual_en    = sample_valid_i && (phase_q != PH_BLIND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_BLIND;
      stand_cnt_q <= '0;
      blind_cnt_q <= '0;
    end else begin
      if (edge_w || stand_hit) stand_cnt_q <= '0;
      else                     stand_cnt_q <= stand_cnt_q + 1'b1;

      if (stand_hit) begin
        phase_q     <= PH_BLIND;
        blind_cnt_q <= '0;
      end else begin
        unique case (phase_q)
          PH_BLIND: begin
            if (blind_done) phase_q <= PH_ACQ;
            else            blind_cnt_q <= blind_cnt_q + 1'b1;
          end
          PH_ACQ:  if (cal_load_w) phase_q <= PH_RUN;
          default: ;
        endcase
      end
    end
  end

  spd_edge_qual #(.SW(SAMPLE_W), .EDGE_THR(EDGE_THR)) i_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (qual_en),
    .clr_i    (phase_q == PH_BLIND),
    .x_i      (sample_i),
    .edge_o   (edge_w),
    .is_peak_o(is_peak_w),
    .extreme_o(extreme_w)
  );

  spd_offset_loop #(
    .SW(SAMPLE_W), .DAC_W(DAC_W), .DEAD_BAND(DEAD_BAND), .CAL_EDGES(CAL_EDGES)
  ) i_loop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_w),
    .is_peak_i (is_peak_w),
    .extreme_i (extreme_w),
    .clr_i     (phase_q == PH_BLIND),
    .acq_i     (phase_q == PH_ACQ),
    .run_i     (phase_q == PH_RUN),
    .cal_load_o(cal_load_w),
    .dac_o     (dac_code_o)
  );

  spd_zero_cross #(
    .SW(SAMPLE_W), .DAC_W(DAC_W), .HYST(HYST), .LIMIT_THR(LIMIT_THR)
  ) i_zc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(sample_valid_i),
    .run_i  (phase_q == PH_RUN),
    .x_i    (sample_i),
    .dac_i  (dac_code_o),
    .speed_o(speed_o)
  );
endmodule

// File: rtl/speed_offset_tracker_chk.sv
module speed_offset_tracker_chk
  import spd_cal_pkg::*;
#(
  parameter int DAC_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sample_valid_i,
  input logic                    speed_o,
  input logic signed [DAC_W-1:0] dac_code_o,
  input cal_phase_e              phase_q,
  input logic                    stand_hit
);
  assert_off_uncal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_RUN) |=> !speed_o);

  assert_dac_single_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN) |=> (phase_q != PH_RUN) || (dac_code_o == $past(dac_code_o)) ||
      (dac_code_o == $past(dac_code_o) + DAC_W'(1)) || (dac_code_o == $past(dac_code_o) - DAC_W'(1)));

  assert_hold_without_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_valid_i && phase_q == PH_RUN) |=> $stable(speed_o));

  assert_standstill_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stand_hit |=> (phase_q == PH_BLIND));

  assert_blind_code_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BLIND && !stand_hit) |=> $stable(dac_code_o));
endmodule

bind speed_offset_tracker speed_offset_tracker_chk #(.DAC_W(DAC_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_valid_i(sample_valid_i),
  .speed_o       (speed_o),
  .dac_code_o    (dac_code_o),
  .phase_q       (phase_q),
  .stand_hit     (stand_hit)
);

// File: tb/test_speed_offset_tracker.sv
module test_speed_offset_tracker;
  localparam int SW = 10;
  localparam int DW = 8;
  localparam int AMP = 40;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 valid = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic signed [DW-1:0] dac;
  logic                 speed;

  int n_chk = 0, n_fail = 0;
  int cur = 0;
  int rises = 0, toggles = 0, hi_cnt = 0;
  bit watch = 1'b0;
  logic prev_speed = 1'b0;

  always #5 clk = ~clk;

  speed_offset_tracker #(
    .SAMPLE_W(SW), .DAC_W(DW), .EDGE_THR(8), .LIMIT_THR(6), .HYST(1),
    .DEAD_BAND(2), .CAL_EDGES(3), .STANDSTILL_CYC(400), .BLIND_CYC(64)
  ) i_speed_offset_tracker (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .sample_i(sample),
    .dac_code_o(dac), .speed_o(speed)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (speed !== prev_speed) toggles++;
      if (speed && !prev_speed) rises++;
      if (watch && speed) hi_cnt++;
    end
    prev_speed = speed;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int v);
    @(negedge clk);
    sample = SW'(v);
    valid  = 1'b1;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) drive(cur);
  endtask

  task automatic go_to(input int tgt);
    while (cur != tgt) begin
      if (tgt > cur) cur += (tgt - cur > 4) ? 4 : tgt - cur;
      else           cur -= (cur - tgt > 4) ? 4 : cur - tgt;
      drive(cur);
    end
  endtask

  task automatic cycles(input int off, input int n);
    for (int i = 0; i < n; i++) begin
      go_to(off + AMP);
      go_to(off - AMP);
    end
  endtask

  task automatic do_reset(input int start);
    rst_n = 1'b0;
    valid = 1'b0;
    cur   = start;
    sample = SW'(start);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 speed after reset", int'(speed), 0);
    chk("R1 dac after reset", int'(dac), 0);
  endtask

  task automatic calibrate(input int off, input string tag);
    hold(70);
    hi_cnt = 0;
    watch  = 1'b1;
    go_to(off + AMP);
    go_to(off - AMP);
    go_to(off + AMP);
    watch = 1'b0;
    chk({"R2 low before third reversal ", tag}, hi_cnt, 0);
    go_to(off - AMP);
    cycles(off, 1);
    hold(2);
    chk({"R3 midpoint code ", tag}, int'(dac), off);
  endtask

  initial begin
    int offs[5] = '{-60, -20, 0, 17, 45};
    int t0;
    // offset sweep: midpoint loading and pulse count
    foreach (offs[k]) begin
      do_reset(offs[k] - AMP);
      calibrate(offs[k], $sformatf("off=%0d", offs[k]));
      rises = 0;
      cycles(offs[k], 4);
      hold(2);
      chk($sformatf("R5 one rise per period off=%0d", offs[k]), rises, 4);
      chk($sformatf("R5 low at valley off=%0d", offs[k]), int'(speed), 0);
    end

    // R4: reversals of exactly EDGE_THR do not qualify
    do_reset(-20);
    hold(70);
    hi_cnt = 0;
    watch  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      go_to(-12);
      go_to(-20);
    end
    watch = 1'b0;
    chk("R4 no switching during sub-threshold wiggle", hi_cnt, 0);
    cycles(20, 3);
    hold(2);
    chk("R4 code from real extremes only", int'(dac), 20);

    // R6 small swings, R7 dead band, R8 standstill, R9 blind window
    do_reset(-AMP);
    calibrate(0, "off=0");
    go_to(4);
    hold(2);
    chk("R5 high after crossing", int'(speed), 1);
    t0 = toggles;
    for (int i = 0; i < 12; i++) begin
      go_to(-4);
      go_to(4);
    end
    hold(2);
    chk("R6 no toggles inside limit", toggles - t0, 0);
    chk("R6 output level kept", int'(speed), 1);
    go_to(-AMP);
    cycles(2, 6);
    hold(2);
    chk("R7 drift within dead band ignored", int'(dac), 0);
    cycles(7, 8);
    hold(2);
    chk("R7 drift settles at edge of dead band", int'(dac), 5);
    rises = 0;
    cycles(7, 2);
    hold(2);
    chk("R7 switching continues after drift", rises, 2);

    hold(440);
    chk("R8 output forced low at standstill", int'(speed), 0);
    chk("R8 code retained at standstill", int'(dac), 5);
    drive(300);
    hold(60);
    chk("R9 spike in blind window no effect on output", int'(speed), 0);
    calibrate(7, "after standstill");
    rises = 0;
    cycles(7, 2);
    hold(2);
    chk("R9 switching resumes after recalibration", rises, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule